// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the access address for a synchronous burst memory. A new external address is captured whenever either of two independent address-strobe inputs is asserted. The upper address bits are then held, and the two low bits step through a four-beat burst, one step per clock, for as long as the advance input is asserted.

A static order-select input picks one of two step orders. Linear order counts upward from the starting offset and wraps modulo 4. Interleaved order combines the starting offset with the beat count by bitwise XOR. When the select input is low, interleaved order is used; this matches a mode pin that is pulled to its default level when left unconnected.

Bursts are optional. A fresh address can be loaded on every clock with no idle cycle in between. An output flag shows that a burst address has been captured since reset.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is active and after it is released, until the first load, `addr_out` is 0 and `burst_act` is 0.
- R2: A clock edge with `strb_a` or `strb_b` high (either one or both) captures `addr_in`, and `addr_out` equals it in the next cycle (beat 0).
- R3: With `ord_lin`=1 (linear), the low two bits of `addr_out` at beat n equal (start + n) mod 4, where start is `addr_in[1:0]` at load.
- R4: With `ord_lin`=0 (interleaved, the default level), the low two bits at beat n equal start XOR n.
- R5: On an edge with no strobe and `adv` low, `addr_out` keeps its value.
- R6: Between loads, `addr_out[ADDR_W-1:2]` keeps the value captured at load.
- R7: When a strobe and `adv` are both high on the same edge, the new address is loaded and the old burst is not advanced.
- R8: After four advances the low bits wrap back to the starting offset, and the burst keeps cycling.
- R9: Loads on consecutive clock edges each take effect, with no lost cycle.
- R10: `adv` has no effect before the first load: `addr_out` stays 0.
- R11: `burst_act` goes to 1 on the first load and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strb_a | input | 1 | First address strobe; loads `addr_in` |
| strb_b | input | 1 | Second address strobe; loads `addr_in` |
| adv | input | 1 | Advance the burst by one beat |
| ord_lin | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current access address |
| burst_act | output | 1 | A burst address has been loaded |

## Verification
Directed bursts load each of the four starting offsets under both orders. Each burst is advanced through five beats, and every beat is compared against a fixed table for that order. A wrong order, a wrong offset or a missing wrap shows up here. Random traffic mixes the two strobes, `adv` and idle cycles. This separates the cases load-wins-over-advance, hold-without-advance and back-to-back loads, and it confirms that the upper bits do not move. A short leading phase that raises `adv` before any load shows that advancing is ignored until an address exists.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef struct packed {
        beat_t start;
        beat_t beat;
        logic  act;
    } seq_state_t;
endpackage

// File: rtl/burst_load_arb.sv
module burst_load_arb (
    input  logic strb_a,
    input  logic strb_b,
    input  logic adv,
    input  logic act,
    output logic load,
    output logic step
);
    always_comb begin
        load = strb_a | strb_b;
        // a load always wins over advancing the running burst
        step = !load && adv && act;
    end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
(
    input  beat_t start,
    input  beat_t beat,
    input  logic  ord_lin,
    output beat_t offset
);
    beat_t lin_off;
    beat_t ilv_off;

    always_comb begin
        lin_off = start + beat;
    end

    for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
        assign ilv_off[b] = start[b] ^ beat[b];
    end

    always_comb begin
        offset = ord_lin ? lin_off : ilv_off;
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strb_a,
    input  logic              strb_b,
    input  logic              adv,
    input  logic              ord_lin,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              burst_act
);
    localparam int UP_W = ADDR_W - BEAT_W;

    seq_state_t          st_d, st_q;
    logic [UP_W-1:0]     upper_d, upper_q;
    logic                load, step;
    beat_t               offset;

    burst_load_arb i_arb (
        .strb_a (strb_a),
        .strb_b (strb_b),
        .adv    (adv),
        .act    (st_q.act),
        .load   (load),
        .step   (step)
    );

    burst_order_map i_map (
        .start   (st_q.start),
        .beat    (st_q.beat),
        .ord_lin (ord_lin),
        .offset  (offset)
    );

    always_comb begin
        st_d    = st_q;
        upper_d = upper_q;
        if (load) begin
            upper_d    = addr_in[ADDR_W-1:BEAT_W];
            st_d.start = addr_in[BEAT_W-1:0];
            st_d.beat  = '0;
            st_d.act   = 1'b1;
        end else if (step) begin
            st_d.beat = st_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            upper_q <= '0;
        end else begin
            st_q    <= st_d;
            upper_q <= upper_d;
        end
    end

    assign addr_out  = {upper_q, offset};
    assign burst_act = st_q.act;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strb_a,
    input logic              strb_b,
    input logic              adv,
    input logic              ord_lin,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic              burst_act
);
    logic ld;
    assign ld = strb_a | strb_b;

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> addr_out == $past(addr_in)); // R2

    AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && adv && burst_act && ord_lin) |=>
        (!ord_lin || addr_out[1:0] == $past(addr_out[1:0]) + 2'd1)); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !adv) |=> (!$stable(ord_lin) || $stable(addr_out))); // R5

    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(addr_out[ADDR_W-1:2])); // R6

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_act |-> addr_out == '0); // R10

    AST_ACT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> burst_act); // R11

    AST_ACT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        burst_act |=> burst_act); // R11
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb_a    (strb_a),
    .strb_b    (strb_b),
    .adv       (adv),
    .ord_lin   (ord_lin),
    .addr_in   (addr_in),
    .addr_out  (addr_out),
    .burst_act (burst_act)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;
    localparam int ADDR_W = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              strb_a = 1'b0, strb_b = 1'b0, adv = 1'b0, ord_lin = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [ADDR_W-1:0] addr_out;
    logic              burst_act;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // expected-value model state
    logic [ADDR_W-3:0] m_up = '0;
    logic [1:0]        m_start = '0;
    logic [1:0]        m_beat = '0;
    logic              m_act = 1'b0;

    // order tables, indexed by {start, beat}
    localparam logic [1:0] LIN_T [16] = '{
        2'd0, 2'd1, 2'd2, 2'd3,  2'd1, 2'd2, 2'd3, 2'd0,
        2'd2, 2'd3, 2'd0, 2'd1,  2'd3, 2'd0, 2'd1, 2'd2};
    localparam logic [1:0] ILV_T [16] = '{
        2'd0, 2'd1, 2'd2, 2'd3,  2'd1, 2'd0, 2'd3, 2'd2,
        2'd2, 2'd3, 2'd0, 2'd1,  2'd3, 2'd2, 2'd1, 2'd0};

    always #5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W)) i_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .strb_a(strb_a), .strb_b(strb_b),
        .adv(adv), .ord_lin(ord_lin), .addr_in(addr_in),
        .addr_out(addr_out), .burst_act(burst_act)
    );

    function automatic logic [ADDR_W-1:0] exp_addr();
        logic [1:0] off;
        off = ord_lin ? LIN_T[{m_start, m_beat}] : ILV_T[{m_start, m_beat}];
        return {m_up, off};
    endfunction

    task automatic chk(input string tag, input logic [ADDR_W-1:0] act_v,
                       input logic [ADDR_W-1:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act_v, exp_v);
        end
    endtask

    // drive one cycle at negedge, update model at posedge, check at next negedge
    task automatic cyc(input logic sa, input logic sb, input logic a,
                       input logic [ADDR_W-1:0] ai, input string tag);
        strb_a = sa; strb_b = sb; adv = a; addr_in = ai;
        @(posedge clk);
        if (sa || sb) begin
            m_up = ai[ADDR_W-1:2]; m_start = ai[1:0]; m_beat = 2'd0; m_act = 1'b1;
        end else if (a && m_act) begin
            m_beat = m_beat + 2'd1;
        end
        @(negedge clk);
        chk(tag, addr_out, exp_addr());
        chk("R11", {{(ADDR_W-1){1'b0}}, burst_act}, {{(ADDR_W-1){1'b0}}, m_act});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] base;
        string tag;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk("R1", addr_out, '0);
        chk("R1", {{(ADDR_W-1){1'b0}}, burst_act}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", addr_out, '0);
        // R10: advancing before any load is ignored
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b1, 20'hABCDE, "R10");

        // R3 / R4 / R8: every offset, both orders, five advances to show the wrap
        for (int o = 0; o < 2; o++) begin
            ord_lin = o[0];
            for (int s = 0; s < 4; s++) begin
                base = {18'(32'h1A5 + s * 7), s[1:0]};
                cyc(s[0], ~s[0], 1'b0, base, "R2");
                for (int b = 0; b < 5; b++)
                    cyc(1'b0, 1'b0, 1'b1, '0, (b == 3) ? "R8" : (o == 1 ? "R3" : "R4"));
                // R6: upper bits still the loaded ones
                chk("R6", {addr_out[ADDR_W-1:2], 2'b00}, {base[ADDR_W-1:2], 2'b00});
            end
        end

        // R7: load and advance together
        ord_lin = 1'b1;
        cyc(1'b1, 1'b0, 1'b0, 20'h00011, "R2");
        cyc(1'b0, 1'b0, 1'b1, '0, "R3");
        cyc(1'b0, 1'b1, 1'b1, 20'h7FFF2, "R7");
        // R9: back-to-back loads
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b0, 20'(32'h30000 + i * 5), "R9");
        // R5: idle hold
        cyc(1'b0, 1'b0, 1'b0, 20'hFFFFF, "R5");

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            logic sa, sb, a;
            sa = ($urandom_range(0, 5) == 0);
            sb = ($urandom_range(0, 5) == 0);
            a  = ($urandom_range(0, 2) != 0);
            if (n % 500 == 0) ord_lin = $urandom_range(0, 1) == 1;
            if (sa && sb)      tag = "R9";
            else if (sa || sb) tag = a ? "R7" : "R2";
            else if (a)        tag = ord_lin ? "R3" : "R4";
            else               tag = "R5";
            cyc(sa, sb, a, 20'($urandom), tag);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule